// File: doc/BRIEF.md
# Shared-Pin GPIO Port Controller

This block manages eight package pins that a dedicated bus function (address or data lines, for example) also needs. A 16-bit register interface selects, pin by pin, whether the pin carries the dedicated signal or acts as a general-purpose I/O. When a pin is in GPIO mode, a direction bit decides whether it drives a stored data value or is only sampled. Sampled levels pass through a synchroniser before software can read them.

The controller drives a registered output value and a registered output enable for each pin. The pad cells themselves are outside the block. At reset every control bit is clear, so every pin starts on its dedicated function and the bus can boot without any configuration. Software then moves pins to GPIO by setting their select bits.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset the direction, data and function-select registers all read 0, so every pin is on its dedicated function.
- R2: While a pin's select bit is 0, its pad_out and pad_oe follow alt_out and alt_oe one cycle later, whatever its direction bit holds.
- R3: While a pin's select bit is 1 and its direction bit is 1, pad_oe is 1 and pad_out equals the stored data bit, one cycle after the registers change.
- R4: While a pin's select bit is 1 and its direction bit is 0, pad_oe is 0, and a write to that pin's data bit does not make it drive.
- R5: Reading the data field of a GPIO input pin returns the pin level after the synchroniser. A change on pin_in is first visible in rdata three clock edges after it is sampled: two synchroniser stages, then the read register.
- R6: The stored data bit is kept across direction changes, so a pin switched to output drives the last value written to it.
- R7: Byte address 0 holds direction in bits 15:8 and data in bits 7:0. Byte address 2 holds select in bits 7:0, and bits 15:8 there always read 0 and ignore writes. Odd addresses read 0 and ignore writes.
- R8: wr_be[1] enables the write of bits 15:8 and wr_be[0] enables the write of bits 7:0. A lane whose enable is 0 keeps its value.
- R9: For a pin that is an output, or on its dedicated function, the data field reads back the stored data bit.
- R10: rdata is registered. It shows the word at the address presented on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register byte address |
| wdata | input | 16 | Register write data |
| wr_be | input | 2 | Byte-lane write enables |
| rdata | output | 16 | Registered read data |
| pin_in | input | 8 | Asynchronous pin levels |
| alt_out | input | 8 | Dedicated function output value |
| alt_oe | input | 8 | Dedicated function output enable |
| pad_out | output | 8 | Registered pin output value |
| pad_oe | output | 8 | Registered pin output enable |

## Verification
The assertions check the pin mux on every cycle: dedicated pins track alt_out and alt_oe, GPIO output pins drive their stored data, and GPIO input pins never drive. They also check that the select word's upper byte reads 0 and that a disabled byte lane holds its value. Only the bench scenarios can show the read-back path. That includes the exact synchroniser latency on pin_in, the choice between the live level and the stored bit in the data field, and the retention of data across direction changes.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int PORT_PINS   = 8;
  localparam int PORT_WORD_W = 2 * PORT_PINS;
  localparam int PORT_ADDR_W = 2;
  localparam int PORT_SYNC   = 2;

  // Byte offsets of the two register words
  localparam logic [PORT_ADDR_W-1:0] OFS_DIRDATA = 2'd0;
  localparam logic [PORT_ADDR_W-1:0] OFS_SELECT  = 2'd2;

  typedef enum logic [1:0] {
    REG_NONE    = 2'd0,
    REG_DIRDATA = 2'd1,
    REG_SELECT  = 2'd2
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [PORT_ADDR_W-1:0] a);
    if (a == OFS_DIRDATA)     return REG_DIRDATA;
    else if (a == OFS_SELECT) return REG_SELECT;
    else                      return REG_NONE;
  endfunction
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_port_pkg::*;
#(
  parameter int PINS   = PORT_PINS,
  parameter int ADDR_W = PORT_ADDR_W,
  localparam int WORD_W = 2 * PINS,
  localparam int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  wr_be,
  output logic [PINS-1:0]   dir_q,
  output logic [PINS-1:0]   dat_q,
  output logic [PINS-1:0]   sel_q
);
  reg_sel_e target;
  logic     wr_dirdata;
  logic     wr_select;

  always_comb begin
    target     = decode_addr(addr);
    wr_dirdata = wr_en && (target == REG_DIRDATA);
    wr_select  = wr_en && (target == REG_SELECT);
  end

  // Upper lane of word 0: direction
  always_ff @(posedge clk) begin
    if (rst)                       dir_q <= '0;
    else if (wr_dirdata && wr_be[1]) dir_q <= wdata[WORD_W-1:PINS];
  end

  // Lower lane of word 0: data, kept across direction changes
  always_ff @(posedge clk) begin
    if (rst)                       dat_q <= '0;
    else if (wr_dirdata && wr_be[0]) dat_q <= wdata[PINS-1:0];
  end

  // Lower lane of word 2: select; upper lane has no storage
  always_ff @(posedge clk) begin
    if (rst)                      sel_q <= '0;
    else if (wr_select && wr_be[0]) sel_q <= wdata[PINS-1:0];
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int PINS   = 8,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] async_in,
  output logic [PINS-1:0] sync_out
);
  logic [PINS-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] sel_q,
  input  logic [PINS-1:0] dir_q,
  input  logic [PINS-1:0] dat_q,
  input  logic [PINS-1:0] alt_out,
  input  logic [PINS-1:0] alt_oe,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe
);
  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic nxt_out;
    logic nxt_oe;

    always_comb begin
      if (sel_q[p]) begin
        nxt_out = dat_q[p];
        nxt_oe  = dir_q[p];
      end else begin
        nxt_out = alt_out[p];
        nxt_oe  = alt_oe[p];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[p] <= 1'b0;
        pad_oe[p]  <= 1'b0;
      end else begin
        pad_out[p] <= nxt_out;
        pad_oe[p]  <= nxt_oe;
      end
    end
  end
endmodule

// File: rtl/gpio_readback.sv
module gpio_readback
  import gpio_port_pkg::*;
#(
  parameter int PINS   = PORT_PINS,
  parameter int ADDR_W = PORT_ADDR_W,
  localparam int WORD_W = 2 * PINS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PINS-1:0]   dir_q,
  input  logic [PINS-1:0]   dat_q,
  input  logic [PINS-1:0]   sel_q,
  input  logic [PINS-1:0]   pin_sync,
  output logic [WORD_W-1:0] rdata
);
  logic [PINS-1:0]   data_view;
  logic [WORD_W-1:0] word_nxt;

  // Input GPIO pins show the live level, all others the stored bit
  for (genvar p = 0; p < PINS; p++) begin : g_view
    assign data_view[p] = (sel_q[p] && !dir_q[p]) ? pin_sync[p] : dat_q[p];
  end

  always_comb begin
    unique case (decode_addr(addr))
      REG_DIRDATA: word_nxt = {dir_q, data_view};
      REG_SELECT:  word_nxt = {{PINS{1'b0}}, sel_q};
      default:     word_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= word_nxt;
  end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_port_pkg::*;
#(
  parameter int PINS        = PORT_PINS,
  parameter int ADDR_W      = PORT_ADDR_W,
  parameter int SYNC_STAGES = PORT_SYNC,
  localparam int WORD_W = 2 * PINS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [1:0]        wr_be,
  output logic [WORD_W-1:0] rdata,
  input  logic [PINS-1:0]   pin_in,
  input  logic [PINS-1:0]   alt_out,
  input  logic [PINS-1:0]   alt_oe,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe
);
  logic [PINS-1:0] dir_q;
  logic [PINS-1:0] dat_q;
  logic [PINS-1:0] sel_q;
  logic [PINS-1:0] pin_sync;

  gpio_regfile #(.PINS(PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .wr_be(wr_be), .dir_q(dir_q), .dat_q(dat_q), .sel_q(sel_q)
  );

  gpio_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(pin_sync)
  );

  gpio_pin_mux #(.PINS(PINS)) u_mux (
    .clk(clk), .rst(rst), .sel_q(sel_q), .dir_q(dir_q), .dat_q(dat_q),
    .alt_out(alt_out), .alt_oe(alt_oe), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  gpio_readback #(.PINS(PINS), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .addr(addr), .dir_q(dir_q), .dat_q(dat_q),
    .sel_q(sel_q), .pin_sync(pin_sync), .rdata(rdata)
  );
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk #(
  parameter int PINS   = 8,
  parameter int ADDR_W = 2,
  localparam int WORD_W = 2 * PINS
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        wr_be,
  input logic [WORD_W-1:0] rdata,
  input logic [PINS-1:0]   alt_out,
  input logic [PINS-1:0]   alt_oe,
  input logic [PINS-1:0]   pad_out,
  input logic [PINS-1:0]   pad_oe,
  input logic [PINS-1:0]   dir_q,
  input logic [PINS-1:0]   dat_q,
  input logic [PINS-1:0]   sel_q
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (dir_q == '0 && dat_q == '0 && sel_q == '0)); // R1

  AST_DEDICATED_FOLLOWS: assert property (@(posedge clk) disable iff (rst || !armed)
    ((((pad_out ^ $past(alt_out)) | (pad_oe ^ $past(alt_oe))) & ~$past(sel_q)) == '0)); // R2

  AST_GPIO_DRIVES: assert property (@(posedge clk) disable iff (rst || !armed)
    ((((pad_out ^ $past(dat_q)) | ~pad_oe) & $past(sel_q & dir_q)) == '0)); // R3

  AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (rst || !armed)
    ((pad_oe & $past(sel_q & ~dir_q)) == '0)); // R4

  AST_SEL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(addr) == 2'd2) |-> (rdata[WORD_W-1:PINS] == '0)); // R7

  AST_LANE_HOLD_DIR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd0 && !wr_be[1]) |=> $stable(dir_q)); // R8

  AST_LANE_HOLD_DAT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd0 && !wr_be[0]) |=> $stable(dat_q)); // R8
endmodule

bind gpio_mux_port gpio_mux_port_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_be(wr_be),
  .rdata(rdata), .alt_out(alt_out), .alt_oe(alt_oe), .pad_out(pad_out),
  .pad_oe(pad_oe), .dir_q(dir_q), .dat_q(dat_q), .sel_q(sel_q)
);

// File: tb/sim_gpio_mux_port.sv
`timescale 1ns/1ps
module sim_gpio_mux_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  wr_be = '0;
  logic [15:0] rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  alt_out = '0;
  logic [7:0]  alt_oe = '0;
  logic [7:0]  pad_out;
  logic [7:0]  pad_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_dir = '0, m_dat = '0, m_sel = '0;
  logic [15:0] rv;

  always #10 clk = ~clk;

  gpio_mux_port u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .wr_be(wr_be), .rdata(rdata), .pin_in(pin_in), .alt_out(alt_out),
    .alt_oe(alt_oe), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic logic [15:0] exp_word0(input logic [7:0] pins);
    logic [7:0] inmask;
    inmask = m_sel & ~m_dir;
    return {m_dir, (inmask & pins) | (~inmask & m_dat)};
  endfunction

  function automatic logic [7:0] exp_pad_out();
    return (m_sel & m_dat) | (~m_sel & alt_out);
  endfunction

  function automatic logic [7:0] exp_pad_oe();
    return (m_sel & m_dir) | (~m_sel & alt_oe);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
    if (a == 2'd0) begin
      if (be[1]) m_dir = d[15:8];
      if (be[0]) m_dat = d[7:0];
    end else if (a == 2'd2) begin
      if (be[0]) m_sel = d[7:0];
    end
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    check({req, " pad_out"}, {8'h0, pad_out}, {8'h0, exp_pad_out()});
    check({req, " pad_oe"}, {8'h0, pad_oe}, {8'h0, exp_pad_oe()});
    reg_read(2'd0, rv);
    check({req, " word0"}, rv, exp_word0(pin_in));
    reg_read(2'd2, rv);
    check({req, " word2"}, rv, {8'h00, m_sel});
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state, pins on dedicated function
    alt_out = 8'h5A; alt_oe = 8'hC3; pin_in = 8'hFF;
    settle();
    check_all("R1");

    // R2: direction ignored while select is 0
    reg_write(2'd0, 16'hFF00, 2'b10);
    settle();
    check_all("R2");

    // R3 / R4: mixed outputs and inputs in GPIO mode
    reg_write(2'd0, 16'hF0A5, 2'b11);
    reg_write(2'd2, 16'h00FF, 2'b01);
    settle();
    check_all("R3");
    reg_write(2'd0, 16'h0033, 2'b01);
    settle();
    check("R4 input pins undriven", {8'h0, pad_oe & 8'h0F}, 16'h0000);
    check_all("R4");

    // R6: data survives direction change
    reg_write(2'd0, 16'h0000, 2'b10);
    reg_write(2'd0, 16'hFF00, 2'b10);
    settle();
    check("R6 pad_out keeps data", {8'h0, pad_out}, 16'h0033);

    // R9: output pins read stored bit
    reg_read(2'd0, rv);
    check("R9 stored data readback", rv, 16'hFF33);

    // R7: upper select byte ignored, odd address ignored
    reg_write(2'd2, 16'hFF0F, 2'b11);
    reg_read(2'd2, rv);
    check("R7 select upper zero", rv, 16'h000F);
    reg_write(2'd1, 16'h1234, 2'b11);
    reg_write(2'd3, 16'h1234, 2'b11);
    reg_read(2'd1, rv);
    check("R7 odd address reads zero", rv, 16'h0000);
    reg_read(2'd0, rv);
    check("R7 odd write ignored", rv, exp_word0(pin_in));

    // R8: lower lane only leaves direction alone
    reg_write(2'd0, 16'hAB5C, 2'b01);
    reg_read(2'd0, rv);
    check("R8 dir lane held", {8'h0, rv[15:8]}, 16'h00FF);

    // R5: synchroniser latency with all pins as GPIO inputs
    reg_write(2'd2, 16'h00FF, 2'b01);
    reg_write(2'd0, 16'h0000, 2'b10);
    pin_in = 8'h00;
    reg_read(2'd0, rv);
    settle();
    @(negedge clk);
    pin_in = 8'h96;
    @(negedge clk);
    @(negedge clk);
    check("R5 not yet visible", rdata, 16'h0000);
    @(negedge clk);
    check("R5 visible after three edges", rdata, 16'h0096);

    // R10: registered read follows address by one cycle
    addr = 2'd2;
    #1;
    check("R10 still old word", rdata, 16'h0096);
    @(negedge clk);
    check("R10 new word", rdata, 16'h00FF);

    // Random mix
    for (int i = 0; i < 300; i++) begin
      logic [1:0] a;
      a = ($urandom % 2 == 0) ? 2'd0 : 2'd2;
      reg_write(a, 16'($urandom), 2'($urandom));
      pin_in  = 8'($urandom);
      alt_out = 8'($urandom);
      alt_oe  = 8'($urandom);
      settle();
      check_all("R2/R3/R5/R8 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule